// File: doc/BRIEF.md
# Flash Program/Erase Completion Poller

This block sits on the controller side of a parallel flash device. Command issue and data transfer happen elsewhere. Once a program or an erase has been started in the device, a start pulse hands the poller four things: the kind of operation, the watch method, the bit value the program is expected to leave, and an address that is valid for the operation. A valid address is the programmed location itself, or any location inside the block being erased. The poller then reads the device status over and over at that address and decides, from the meaning of the status bits, when the operation has finished. It does not look at a ready pin.

Two watch methods are offered. In data-poll mode the poller examines the polling bit of each read. In toggle mode it compares the toggle bit of each read with the same bit from the read before; the very first read after start only records a reference value. An operation aimed at a protected block finishes silently after a short burst of toggling, and toggle mode ends normally on it. A per-job limit on the number of reads bounds the wait. When the limit runs out, a timeout level is raised and the poller goes idle.

Reads leave the block as a valid/ready request carrying an address. Once valid is raised, the address is held until ready is seen high at a clock edge. Only one read is outstanding at a time. The device answers with a single-cycle response-valid strobe and its data. The poller accepts a response in any cycle in which a read is outstanding and offers no back-pressure, so the response side has no ready signal. A response strobe that arrives while no read is outstanding is not used.

Top module: `flash_done_poller`

## Requirements
- R1: After reset, busy_o, done_o, timeout_o and rd_req_valid_o are all 0, and rd_req_valid_o is 0 whenever busy_o is 0.
- R2: A start_i pulse while idle raises busy_o in the next cycle, together with rd_req_valid_o carrying the captured addr_i. Valid and address stay unchanged until rd_req_ready_i is seen high. The next request is raised only after the response to the current one has been taken.
- R3: Data-poll watch (method_i = 0) on a program (op_i = 0): the job is finished when bit 7 of the response equals exp_bit_i; otherwise polling goes on.
- R4: Data-poll watch on an erase (op_i = 1): the job is finished when bit 7 of the response is 1, whatever the value of exp_bit_i.
- R5: Toggle watch (method_i = 1): the first response after start only stores its bit 6 as the reference. Each later response finishes the job if its bit 6 equals the bit 6 of the previous response, and otherwise becomes the new reference. Bit 7 has no effect in this mode.
- R6: Completion drives done_o high for exactly one cycle. busy_o falls in the same cycle, and no further read is requested.
- R7: If max_polls_i responses have been taken without completion, timeout_o rises, busy_o falls and done_o stays 0. A max_polls_i of 0 allows one read, the same as 1. A response that completes the job on the last permitted read gives done, not timeout. timeout_o holds until the next accepted start, which clears it.
- R8: A start_i pulse while busy_o is high is ignored: the job in progress keeps its address, its operation kind and its method.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin polling (taken only while idle) |
| op_i | input | 1 | 0 = program, 1 = erase |
| method_i | input | 1 | 0 = data-poll watch, 1 = toggle watch |
| exp_bit_i | input | 1 | Value bit 7 should reach when a program ends |
| addr_i | input | AW | Address that is valid for the operation being watched |
| max_polls_i | input | CW | Largest number of reads allowed before timeout |
| rd_req_valid_o | output | 1 | Status read request valid |
| rd_req_ready_i | input | 1 | Device accepts the request |
| rd_req_addr_o | output | AW | Address of the status read |
| rd_rsp_valid_i | input | 1 | Response strobe, one cycle per read |
| rd_rsp_data_i | input | DW | Status data returned |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | Read budget exhausted (held until next start) |

## Verification
The hardest cases to reach are those where completion and budget exhaustion fall on the same response, and the toggle-mode case where the first read would wrongly end the job if it were compared against a reset value. A table of response sequences reaches both. Each entry has its own read limit, and a limit of 0 or 1 is included. The first byte of some toggle entries is chosen so that a comparison against a reset value would end the job one read early. A directed test then sends a second start, with a different address and a conflicting operation kind, while a request is being held back by a low ready. The response data is chosen so that only the original job finishes on it.

// File: rtl/fpoll_pkg.sv
package fpoll_pkg;

  typedef enum logic {
    OP_PROGRAM = 1'b0,
    OP_ERASE   = 1'b1
  } op_kind_e;

  typedef enum logic {
    WATCH_DATA   = 1'b0,
    WATCH_TOGGLE = 1'b1
  } watch_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } poll_state_e;

  typedef struct packed {
    op_kind_e op;
    watch_e   watch;
    logic     exp_bit;
  } job_t;

endpackage

// File: rtl/fpoll_judge.sv
// Decides from one status response whether the watched operation is over.
module fpoll_judge
  import fpoll_pkg::*;
#(
  parameter int DW         = 8,
  parameter int DATA_BIT   = 7,
  parameter int TOGGLE_BIT = 6
) (
  input  logic [DW-1:0] rsp_data,
  input  job_t          job,
  input  logic          ref_valid,
  input  logic          ref_bit,
  output logic          finished,
  output logic          tog_bit
);

  logic poll_bit;
  logic data_finished;
  logic toggle_finished;

  assign poll_bit = rsp_data[DATA_BIT];
  assign tog_bit  = rsp_data[TOGGLE_BIT];

  // Program: the polling bit reads inverted until the cell holds the value.
  // Erase: the polling bit reads 0 until the erased state 1 appears.
  always_comb begin
    if (job.op == OP_ERASE) data_finished = poll_bit;
    else                    data_finished = (poll_bit == job.exp_bit);
  end

  // Toggle: finished once two successive reads show the same toggle bit.
  assign toggle_finished = ref_valid && (tog_bit == ref_bit);

  always_comb begin
    unique case (job.watch)
      WATCH_DATA:   finished = data_finished;
      WATCH_TOGGLE: finished = toggle_finished;
      default:      finished = 1'b0;
    endcase
  end

endmodule

// File: rtl/fpoll_budget.sv
// Counts responses taken in the current job and flags the final allowed one.
module fpoll_budget #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic [CW-1:0] limit,
  output logic          last
);

  localparam int XW = CW + 1;

  logic [CW-1:0] count_q;
  logic [XW-1:0] next_count;

  assign next_count = {1'b0, count_q} + XW'(1);
  // A limit of 0 behaves like 1: the first read is always the final one.
  assign last = (next_count >= {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count_q <= '0;
    else if (clr)  count_q <= '0;
    else if (step) count_q <= next_count[CW-1:0];
  end

endmodule

// File: rtl/fpoll_toggle_ref.sv
// Holds the toggle bit of the previous response and whether one exists yet.
module fpoll_toggle_ref (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic load,
  input  logic d,
  output logic ref_valid,
  output logic ref_bit
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_valid <= 1'b0;
      ref_bit   <= 1'b0;
    end else if (clr) begin
      ref_valid <= 1'b0;
      ref_bit   <= 1'b0;
    end else if (load) begin
      ref_valid <= 1'b1;
      ref_bit   <= d;
    end
  end

endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
  import fpoll_pkg::*;
#(
  parameter int AW         = 20,
  parameter int DW         = 8,
  parameter int CW         = 16,
  parameter int DATA_BIT   = 7,
  parameter int TOGGLE_BIT = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          op_i,
  input  logic          method_i,
  input  logic          exp_bit_i,
  input  logic [AW-1:0] addr_i,
  input  logic [CW-1:0] max_polls_i,
  output logic          rd_req_valid_o,
  input  logic          rd_req_ready_i,
  output logic [AW-1:0] rd_req_addr_o,
  input  logic          rd_rsp_valid_i,
  input  logic [DW-1:0] rd_rsp_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          timeout_o
);

  poll_state_e   state_q;
  job_t          job_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] limit_q;
  logic          busy_q, done_q, timeout_q;

  logic accept_start, req_fire, rsp_take;
  logic finished, tog_bit, last_read;
  logic ref_valid, ref_bit;

  assign accept_start = start_i && (state_q == ST_IDLE);
  assign req_fire     = (state_q == ST_ISSUE) && rd_req_ready_i;
  assign rsp_take     = (state_q == ST_WAIT) && rd_rsp_valid_i;

  fpoll_judge #(
    .DW(DW), .DATA_BIT(DATA_BIT), .TOGGLE_BIT(TOGGLE_BIT)
  ) u_judge (
    .rsp_data  (rd_rsp_data_i),
    .job       (job_q),
    .ref_valid (ref_valid),
    .ref_bit   (ref_bit),
    .finished  (finished),
    .tog_bit   (tog_bit)
  );

  fpoll_budget #(.CW(CW)) u_budget (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept_start),
    .step  (rsp_take),
    .limit (limit_q),
    .last  (last_read)
  );

  fpoll_toggle_ref u_ref (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (accept_start),
    .load      (rsp_take),
    .d         (tog_bit),
    .ref_valid (ref_valid),
    .ref_bit   (ref_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      job_q     <= '{op: OP_PROGRAM, watch: WATCH_DATA, exp_bit: 1'b0};
      addr_q    <= '0;
      limit_q   <= '0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      timeout_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept_start) begin
            job_q.op      <= op_kind_e'(op_i);
            job_q.watch   <= watch_e'(method_i);
            job_q.exp_bit <= exp_bit_i;
            addr_q        <= addr_i;
            limit_q       <= max_polls_i;
            busy_q        <= 1'b1;
            timeout_q     <= 1'b0;
            state_q       <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (req_fire) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rsp_take) begin
            if (finished) begin
              // Completion on the last permitted read wins over timeout.
              done_q  <= 1'b1;
              busy_q  <= 1'b0;
              state_q <= ST_IDLE;
            end else if (last_read) begin
              timeout_q <= 1'b1;
              busy_q    <= 1'b0;
              state_q   <= ST_IDLE;
            end else begin
              state_q <= ST_ISSUE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_req_valid_o = (state_q == ST_ISSUE);
  assign rd_req_addr_o  = addr_q;
  assign busy_o         = busy_q;
  assign done_o         = done_q;
  assign timeout_o      = timeout_q;

endmodule

// File: rtl/fpoll_checker.sv
module fpoll_checker #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          rd_req_valid_o,
  input logic          rd_req_ready_i,
  input logic [AW-1:0] rd_req_addr_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          timeout_o
);

  // R1: no read request is raised while idle
  a_r1_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !rd_req_valid_o);

  // R2: a request held off by ready keeps valid and address
  a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid_o && !rd_req_ready_i |=> rd_req_valid_o && $stable(rd_req_addr_o));

  // R6: done lasts one cycle
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6: busy falls exactly as done rises
  a_r6_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && $past(busy_o));

  // R7: a fresh timeout ends the job without done
  a_r7_timeout_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_o) |-> !busy_o && !done_o);

  // R8: a start during a job leaves the read address alone
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i |=> $stable(rd_req_addr_o));

endmodule

bind flash_done_poller fpoll_checker #(.AW(AW)) u_fpoll_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .start_i        (start_i),
  .rd_req_valid_o (rd_req_valid_o),
  .rd_req_ready_i (rd_req_ready_i),
  .rd_req_addr_o  (rd_req_addr_o),
  .busy_o         (busy_o),
  .done_o         (done_o),
  .timeout_o      (timeout_o)
);

// File: tb/flash_done_poller_tb_top.sv
`timescale 1ns/1ps
module flash_done_poller_tb_top;

  localparam int AW = 20;
  localparam int DW = 8;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          op_i = 1'b0;
  logic          method_i = 1'b0;
  logic          exp_bit_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [CW-1:0] max_polls_i = '0;
  logic          rd_req_valid_o;
  logic          rd_req_ready_i = 1'b0;
  logic [AW-1:0] rd_req_addr_o;
  logic          rd_rsp_valid_i = 1'b0;
  logic [DW-1:0] rd_rsp_data_i = '0;
  logic          busy_o, done_o, timeout_o;

  int checks = 0;
  int errors = 0;
  bit all_done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  flash_done_poller #(.AW(AW), .DW(DW), .CW(CW)) dut_i (.*);

  // Outcome codes: 1 = done, 2 = timeout.
  typedef struct packed {
    logic        op;      // 0 program, 1 erase
    logic        meth;    // 0 data poll, 1 toggle
    logic        expb;
    logic [7:0]  lim;
    logic [47:0] seq;     // response bytes, first read in the top byte
    logic [1:0]  want;
    logic [3:0]  nreads;
    logic [19:0] addr;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b1, 8'd10, 48'h00_40_80_00_00_00, 2'd1, 4'd3, 20'h12345}, // R3 exp 1
    '{1'b0, 1'b0, 1'b0, 8'd10, 48'h80_C0_7F_00_00_00, 2'd1, 4'd3, 20'h0ABCD}, // R3 exp 0
    '{1'b1, 1'b0, 1'b0, 8'd10, 48'h00_3F_40_FF_00_00, 2'd1, 4'd4, 20'hF0000}, // R4 erase
    '{1'b0, 1'b1, 1'b0, 8'd10, 48'h40_00_40_40_00_00, 2'd1, 4'd4, 20'h00010}, // R5 toggle
    '{1'b1, 1'b1, 1'b0, 8'd10, 48'h00_40_40_00_00_00, 2'd1, 4'd3, 20'h80000}, // R5 protected burst
    '{1'b0, 1'b1, 1'b1, 8'd10, 48'h80_00_00_00_00_00, 2'd1, 4'd2, 20'h00777}, // R5 bit 7 ignored
    '{1'b0, 1'b0, 1'b1, 8'd3,  48'h00_00_00_00_00_00, 2'd2, 4'd3, 20'h33333}, // R7 timeout
    '{1'b0, 1'b0, 1'b1, 8'd3,  48'h00_00_80_00_00_00, 2'd1, 4'd3, 20'h44444}, // R7 done on last read
    '{1'b0, 1'b0, 1'b1, 8'd0,  48'h00_00_00_00_00_00, 2'd2, 4'd1, 20'h55555}, // R7 limit 0
    '{1'b1, 1'b1, 1'b0, 8'd1,  48'h40_40_00_00_00_00, 2'd2, 4'd1, 20'h66666}  // R5/R7 first read only loads
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Waits for a request, holds ready low for 'stall' cycles, grants it, returns data.
  // Ends at the negedge after the response strobe.
  task automatic serve_read(input logic [7:0] d, input int stall, input logic [AW-1:0] a);
    int guard = 0;
    while (!rd_req_valid_o && guard < 50) begin
      @(negedge clk);
      guard++;
    end
    chk(rd_req_valid_o == 1'b1, "R2 request raised", rd_req_valid_o, 1);
    for (int s = 0; s < stall; s++) @(negedge clk);
    chk(rd_req_valid_o && rd_req_addr_o == a, "R2 request address", rd_req_addr_o, a);
    rd_req_ready_i = 1'b1;
    @(negedge clk);
    rd_req_ready_i = 1'b0;
    chk(rd_req_valid_o == 1'b0, "R2 one outstanding read", rd_req_valid_o, 0);
    rd_rsp_valid_i = 1'b1;
    rd_rsp_data_i  = d;
    @(negedge clk);
    rd_rsp_valid_i = 1'b0;
    rd_rsp_data_i  = '0;
  endtask

  task automatic start_job(input logic op, input logic meth, input logic expb,
                           input logic [AW-1:0] a, input logic [CW-1:0] lim);
    @(negedge clk);
    op_i = op; method_i = meth; exp_bit_i = expb; addr_i = a; max_polls_i = lim;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
    chk(timeout_o == 1'b0, "R7 timeout cleared by start", timeout_o, 0);
  endtask

  task automatic run_vec(input int idx);
    vec_t v = VECS[idx];
    int reads = 0;
    start_job(v.op, v.meth, v.expb, v.addr, CW'(v.lim));
    while (busy_o && reads < 6) begin
      serve_read(v.seq[47-8*reads -: 8], idx % 3, v.addr);
      reads++;
    end
    chk(reads == int'(v.nreads), $sformatf("R3/R4/R5/R7 vec %0d read count", idx), reads, v.nreads);
    chk(busy_o == 1'b0, $sformatf("R6/R7 vec %0d busy low", idx), busy_o, 0);
    chk(done_o == (v.want == 2'd1), $sformatf("R6 vec %0d done", idx), done_o, v.want == 2'd1);
    chk(timeout_o == (v.want == 2'd2), $sformatf("R7 vec %0d timeout", idx), timeout_o, v.want == 2'd2);
    @(negedge clk);
    chk(done_o == 1'b0, $sformatf("R6 vec %0d done single cycle", idx), done_o, 0);
    chk(rd_req_valid_o == 1'b0, $sformatf("R6 vec %0d no further read", idx), rd_req_valid_o, 0);
    if (v.want == 2'd2)
      chk(timeout_o == 1'b1, $sformatf("R7 vec %0d timeout held", idx), timeout_o, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!all_done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy_o == 0, "R1 busy at reset", busy_o, 0);
    chk(done_o == 0, "R1 done at reset", done_o, 0);
    chk(timeout_o == 0, "R1 timeout at reset", timeout_o, 0);
    chk(rd_req_valid_o == 0, "R1 request at reset", rd_req_valid_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy_o == 0 && rd_req_valid_o == 0, "R1 idle after reset", busy_o, 0);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R8: second start (erase, new address) during a held-off request is ignored.
    start_job(1'b0, 1'b0, 1'b0, 20'h0AAAA, 16'd10);
    start_i = 1'b1; op_i = 1'b1; addr_i = 20'h0BBBB;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R8 still busy", busy_o, 1);
    chk(rd_req_addr_o == 20'h0AAAA, "R8 address kept", rd_req_addr_o, 20'h0AAAA);
    // 0x7F finishes a program expecting 0, but not an erase.
    serve_read(8'h7F, 1, 20'h0AAAA);
    chk(done_o == 1'b1, "R8 original program job finished", done_o, 1);
    @(negedge clk);
    chk(rd_req_valid_o == 1'b0 && busy_o == 1'b0, "R8 no second job started", rd_req_valid_o, 0);

    all_done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule